// File: doc/BRIEF.md
# Fixed-Point Requantization Unit

This block narrows a signed two's-complement fixed-point sample from a wide input format to a smaller output format. Each format is fixed at elaboration by a total width and a fraction width. The block drops the surplus fraction bits using one of three rounding methods, chosen at run time. It then fits the rounded value into the output width using one of two run-time overflow policies.

Two flags travel with each result. One says that the rounded value fell outside the output range. The other says that the discarded fraction bits were not all zero. A parameter selects the timing. The result and flags can come straight out of logic, or pass through one register stage whose valid strobe trails the input strobe by one cycle.

The fraction width of the input must not be smaller than that of the output. The number of dropped bits is the difference of the two fraction widths.

Top module: `fxp_requant`

## Requirements
- R1: With rounding code 2'b00 (truncate), the result is the input shifted right arithmetically by the number of dropped bits. This rounds toward negative infinity.
- R2: With rounding code 2'b01 (half-up), the result is the nearest output value, and a value exactly halfway between two output codes goes to the larger one.
- R3: With rounding code 2'b10 (half-even), the result is the nearest output value, and an exact halfway value goes to the neighbour whose output LSB is 0. This code is the package default selection.
- R4: Rounding code 2'b11 gives the same result and flags as truncate.
- R5: With overflow select 1 (saturate), a rounded value above the output range returns the most positive code (0 followed by ones), and one below it returns the most negative code (1 followed by zeros).
- R6: With overflow select 0 (wrap), the result is the low OUT_W bits of the rounded value.
- R7: out_ovf is 1 exactly when the rounded value lies outside the signed OUT_W-bit range, in both overflow policies. out_inexact is 1 exactly when some dropped fraction bit was 1. A rounded value inside the range is passed through unchanged.
- R8: When the output format holds every input value exactly, out_data equals the sign-extended input and both flags are 0.
- R9: With PIPE=1, the result, flags and valid appear one clock after the input. An active-low reset clears out_valid, out_data and both flags. With PIPE=0, the outputs follow the inputs in the same cycle, and out_valid equals in_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks in_data as a sample |
| in_data | input | IN_W | Signed input, IN_FRAC fraction bits |
| rnd_mode | input | 2 | Rounding select: 00 truncate, 01 half-up, 10 half-even, 11 truncate |
| sat_en | input | 1 | Overflow select: 0 wrap, 1 saturate |
| out_valid | output | 1 | Marks out_data as a result |
| out_data | output | OUT_W | Signed result, OUT_FRAC fraction bits |
| out_ovf | output | 1 | Rounded value was outside the output range |
| out_inexact | output | 1 | Dropped fraction bits were nonzero |

## Verification
The block keeps no state other than the optional output register. A wrong rounding increment or a wrong range decision therefore shows up on out_data or the flags for the very sample that caused it, one cycle later when PIPE=1. A wrong tie decision only shows on inputs whose dropped bits form exactly one half, and it moves the result by one LSB. This is why every input code is swept under every mode combination, rather than sampled at random. A wrong valid register shows as out_valid failing to follow a toggling in_valid by exactly one cycle.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

   typedef enum logic [1:0] {
      RND_TRUNC     = 2'b00,
      RND_HALF_UP   = 2'b01,
      RND_HALF_EVEN = 2'b10,
      RND_SPARE     = 2'b11
   } rnd_mode_e;

   typedef enum logic {
      OVF_WRAP = 1'b0,
      OVF_SAT  = 1'b1
   } ovf_mode_e;

   // Selection a caller ties the rounding input to when it has no preference
   localparam rnd_mode_e RND_DEFAULT = RND_HALF_EVEN;

endpackage

// File: rtl/fxp_round.sv
module fxp_round
   import fxp_pkg::*;
#(
   parameter int IN_W = 16,
   parameter int DROP = 4,
   localparam int KW  = IN_W - DROP,
   localparam int QW  = KW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IN_W-1:0] x,
   input  logic [1:0]    mode,
   output logic [QW-1:0] q,
   output logic          inexact
);

   rnd_mode_e sel;
   assign sel = rnd_mode_e'(mode);

   generate
      if (DROP == 0) begin : g_pass
         assign q       = {x[IN_W-1], x};
         assign inexact = 1'b0;
      end else begin : g_drop
         logic [KW-1:0]   kept;
         logic [DROP-1:0] frac;
         logic            half;
         logic            tail_nz;
         logic            tie;
         logic            inc;

         assign kept = x[IN_W-1:DROP];
         assign frac = x[DROP-1:0];
         assign half = frac[DROP-1];

         if (DROP == 1) begin : g_no_tail
            assign tail_nz = 1'b0;
         end else begin : g_tail
            assign tail_nz = |frac[DROP-2:0];
         end

         assign tie     = half & ~tail_nz;
         assign inexact = |frac;

         always_comb begin
            unique case (sel)
               RND_HALF_UP:   inc = half;
               RND_HALF_EVEN: inc = half & (tail_nz | kept[0]);
               default:       inc = 1'b0;
            endcase
         end

         assign q = {kept[KW-1], kept} + {{KW{1'b0}}, inc};

         AST_EXACT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            !inexact |-> ({q, {DROP{1'b0}}} == {x[IN_W-1], x}));                  // R7
         AST_STEP_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(q) == $signed({kept[KW-1], kept})) ||
            ($signed(q) == $signed({kept[KW-1], kept}) + 1));                     // R1
         AST_HALF_UP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == RND_HALF_UP && half) |-> (q != {kept[KW-1], kept}));          // R2
         AST_TIE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == RND_HALF_EVEN && tie) |-> !q[0]);                             // R3
         AST_SPARE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == RND_SPARE) |-> (q == {kept[KW-1], kept}));                    // R4
      end
   endgenerate

endmodule

// File: rtl/fxp_range.sv
module fxp_range
   import fxp_pkg::*;
#(
   parameter int QW    = 13,
   parameter int OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [QW-1:0]    q,
   input  logic             sat,
   output logic [OUT_W-1:0] y,
   output logic             ovf
);

   localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

   ovf_mode_e pol;
   assign pol = ovf_mode_e'(sat);

   generate
      if (QW <= OUT_W) begin : g_fits
         assign y   = {{(OUT_W-QW){q[QW-1]}}, q};
         assign ovf = 1'b0;
      end else begin : g_check
         logic [QW-OUT_W:0] head;
         logic              clamp;

         assign head  = q[QW-1:OUT_W-1];
         assign ovf   = ~((&head) | ~(|head));
         assign clamp = ovf & (pol == OVF_SAT);

         always_comb begin
            if (clamp) y = q[QW-1] ? NEG_LIM : POS_LIM;
            else       y = q[OUT_W-1:0];
         end

         AST_WRAP_NO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
            (pol == OVF_WRAP && ovf) |-> (y != POS_LIM || q[OUT_W-1:0] == POS_LIM)); // R6
      end
   endgenerate

   AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (pol == OVF_SAT && ovf) |-> (y == POS_LIM || y == NEG_LIM));                // R5
   AST_INRANGE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf |-> ($signed(y) == $signed(q)));                                       // R7

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant
   import fxp_pkg::*;
#(
   parameter int IN_W     = 16,
   parameter int IN_FRAC  = 10,
   parameter int OUT_W    = 8,
   parameter int OUT_FRAC = 4,
   parameter bit PIPE     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   input  logic [1:0]       rnd_mode,
   input  logic             sat_en,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data,
   output logic             out_ovf,
   output logic             out_inexact
);

   localparam int DROP = IN_FRAC - OUT_FRAC;
   localparam int KW   = IN_W - DROP;
   localparam int QW   = KW + 1;

   generate
      if (IN_FRAC < OUT_FRAC) begin : g_err_frac
         $fatal(1, "fxp_requant: output fraction wider than input fraction");
      end
      if (IN_FRAC >= IN_W || OUT_FRAC >= OUT_W) begin : g_err_fmt
         $fatal(1, "fxp_requant: a format needs at least one integer bit");
      end
      if (OUT_W < 2) begin : g_err_w
         $fatal(1, "fxp_requant: output width below 2");
      end
   endgenerate

   logic [QW-1:0]    rnd_q;
   logic             rnd_inexact;
   logic [OUT_W-1:0] rng_y;
   logic             rng_ovf;

   fxp_round #(.IN_W(IN_W), .DROP(DROP)) u_round (
      .clk     (clk),
      .rst_n   (rst_n),
      .x       (in_data),
      .mode    (rnd_mode),
      .q       (rnd_q),
      .inexact (rnd_inexact)
   );

   fxp_range #(.QW(QW), .OUT_W(OUT_W)) u_range (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (rnd_q),
      .sat   (sat_en),
      .y     (rng_y),
      .ovf   (rng_ovf)
   );

   generate
      if (PIPE) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               out_data    <= '0;
               out_ovf     <= 1'b0;
               out_inexact <= 1'b0;
            end else begin
               out_valid   <= in_valid;
               out_data    <= rng_y;
               out_ovf     <= rng_ovf;
               out_inexact <= rnd_inexact;
            end
         end

         AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);                                              // R9
         AST_IDLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);                                            // R9
         AST_DATA_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_data == $past(rng_y) && out_ovf == $past(rng_ovf))); // R9
      end else begin : g_comb
         assign out_valid   = in_valid;
         assign out_data    = rng_y;
         assign out_ovf     = rng_ovf;
         assign out_inexact = rnd_inexact;
      end
   endgenerate

endmodule

// File: tb/sim_fxp_requant.sv
module sim_fxp_requant;

   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_run = 0;
   int n_fail = 0;

   // u0: 8-bit input, 4 fraction bits -> 5-bit output, 1 fraction bit (3 dropped), registered
   logic       v0 = 1'b0;
   logic [7:0] x0 = '0;
   logic [1:0] m0 = 2'b00;
   logic       s0 = 1'b0;
   logic       ov0;
   logic [4:0] y0;
   logic       of0, ix0;

   fxp_requant #(.IN_W(8), .IN_FRAC(4), .OUT_W(5), .OUT_FRAC(1), .PIPE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_data(x0), .rnd_mode(m0),
      .sat_en(s0), .out_valid(ov0), .out_data(y0), .out_ovf(of0), .out_inexact(ix0)
   );

   // u1: exact widening 6/2 -> 8/2, combinational
   logic       v1 = 1'b0;
   logic [5:0] x1 = '0;
   logic [1:0] m1 = 2'b00;
   logic       s1 = 1'b0;
   logic       ov1;
   logic [7:0] y1;
   logic       of1, ix1;

   fxp_requant #(.IN_W(6), .IN_FRAC(2), .OUT_W(8), .OUT_FRAC(2), .PIPE(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_data(x1), .rnd_mode(m1),
      .sat_en(s1), .out_valid(ov1), .out_data(y1), .out_ovf(of1), .out_inexact(ix1)
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R9", ov0, 0, "reset out_valid");
      check("R9", {27'd0, y0}, 0, "reset out_data");
      check("R9", {of0, ix0}, 0, "reset flags");
      @(negedge clk);
      rst_n = 1'b1;

      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 256; i++) begin
               int v, fl, rem, q, ey, ept;
               bit eo, ei, up;
               string tag;
               @(negedge clk);
               x0 = i[7:0]; m0 = m[1:0]; s0 = s[0]; v0 = i[0] ^ i[3];
               v  = (i >= 128) ? i - 256 : i;
               fl = v >>> 3;
               rem = v - fl * 8;
               case (m)
                  1: up = (rem >= 4);
                  2: up = (rem > 4) || (rem == 4 && (fl % 2 != 0));
                  default: up = 1'b0;
               endcase
               q  = fl + (up ? 1 : 0);
               ei = (rem != 0);
               eo = (q > 15) || (q < -16);
               ept = q;
               if (s == 1 && q > 15)  ept = 15;
               if (s == 1 && q < -16) ept = -16;
               ey = ((ept % 32) + 32) % 32;
               tag = (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
               @(posedge clk);
               #1;
               if (eo) tag = (s == 1) ? "R5" : "R6";
               check(tag, {27'd0, y0}, ey, $sformatf("data in=%0d mode=%0d sat=%0d", v, m, s));
               check("R7", {30'd0, of0, ix0}, {30'd0, eo, ei},
                     $sformatf("flags {ovf,inexact} in=%0d mode=%0d", v, m));
               check("R9", {31'd0, ov0}, {31'd0, v0}, "out_valid lag");
            end
         end
      end

      for (int i = 0; i < 64; i++) begin
         for (int m = 0; m < 3; m++) begin
            int v;
            @(negedge clk);
            x1 = i[5:0]; m1 = m[1:0]; s1 = i[1]; v1 = i[0];
            v = (i >= 32) ? i - 64 : i;
            #1;
            check("R8", {24'd0, y1}, ((v % 256) + 256) % 256, $sformatf("exact in=%0d", v));
            check("R8", {30'd0, of1, ix1}, 0, "exact flags");
            check("R9", {31'd0, ov1}, {31'd0, v1}, "comb valid");
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule